// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This block carries out unsigned multiplication and division for an accumulator-style processor core. It takes several cycles per operation and retires one result bit each cycle. The core raises `start` for one cycle and supplies four things: the operation, the width, the explicit operand and the current contents of the accumulator pair. The unit then holds `busy` high for a fixed number of cycles and pulses `done` when the updated pair and the flags are ready on its outputs.

Multiplication is MSB-first shift-and-add. Division is restoring shift-subtract. An operation takes 8 cycles at byte width and 16 cycles at word width. The unit checks every division for a zero divisor and for a quotient that does not fit, before the first step runs. A failed division raises a divide-error flag and hands back the accumulator pair unchanged.

The result registers and the flags keep their values between operations. Encodings: `word_sel`=1 selects word width and 0 selects byte width. `op_div`=1 selects division and 0 selects multiplication. The low byte of a register is bits [7:0] and the high byte is bits [15:8].

Top module: `muldiv_seq`

## Requirements
- R1: Byte multiply. `acc_lo_out` = `acc_lo_in[7:0]` × `operand[7:0]` as a 16-bit product, and `acc_hi_out` = `acc_hi_in`.
- R2: Word multiply. {`acc_hi_out`,`acc_lo_out`} = `acc_lo_in` × `operand` as a 32-bit product, with the high half in `acc_hi_out`.
- R3: After a multiply, `flag_c` and `flag_o` are both 1 if the upper half of the product is non-zero and both 0 otherwise. `div_err` is 0. The upper half is bits [15:8] at byte width and `acc_hi_out` at word width.
- R4: Byte divide of `acc_lo_in` by `operand[7:0]`. The quotient goes to `acc_lo_out[7:0]`, the remainder goes to `acc_lo_out[15:8]`, and `acc_hi_out` = `acc_hi_in`.
- R5: Word divide of {`acc_hi_in`,`acc_lo_in`} by `operand`. The quotient goes to `acc_lo_out` and the remainder goes to `acc_hi_out`.
- R6: A divide leaves `flag_c` and `flag_o` at the values they had before it.
- R7: A divide raises `div_err` if the divisor is zero or the quotient exceeds the destination width, and then `acc_lo_out`/`acc_hi_out` equal the inputs that were captured. A divide that succeeds clears `div_err`.
- R8: `busy` is high for exactly 8 cycles (byte) or 16 cycles (word) after the accepting edge. `done` is high for exactly one cycle, on the cycle in which `busy` drops.
- R9: A `start` that arrives while `busy` is high has no effect on the running operation, its result or its timing.
- R10: After reset, `busy`, `done`, `flag_c`, `flag_o`, `div_err`, `acc_lo_out` and `acc_hi_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| word_sel | input | 1 | 1 = word width, 0 = byte width |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| operand | input | W | Multiplier or divisor (byte width uses [7:0]) |
| acc_lo_in | input | W | Low accumulator register contents |
| acc_hi_in | input | W | High accumulator register contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_lo_out | output | W | Updated low accumulator register |
| acc_hi_out | output | W | Updated high accumulator register |
| flag_c | output | 1 | Carry flag |
| flag_o | output | 1 | Overflow flag |
| div_err | output | 1 | Division failed on its most recent use |

## Verification
The checker records the operation, width and accumulator values on the edge where `start` meets an idle unit. It assumes those captured values are the request that the completing result belongs to, and that `start` outside that edge carries no meaning. The checker counts cycles from acceptance to `done` itself, so the latency check does not depend on the inputs staying stable.

The bench changes inputs only on falling edges. While an operation runs, it deliberately presents a second `start` with different data. It mixes random widths and operations with directed cases: the largest products, divisors of zero, and quotients that overflow by exactly one.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;
endpackage

// File: rtl/md_mul_step.sv
// One MSB-first shift-and-add step: the product shifts left one place and
// the multiplicand is added when the multiplier's top bit is set.
module md_mul_step #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod_nx,
    output logic [W-1:0]   mplier_nx
);
    localparam int PW = 2 * W;

    always_comb begin
        prod_nx   = (prod << 1) + (mplier[W-1] ? {{(PW-W){1'b0}}, mcand} : '0);
        mplier_nx = mplier << 1;
    end
endmodule

// File: rtl/md_div_step.sv
// One restoring division step: the next dividend bit shifts into the
// partial remainder, and the divisor is subtracted if it fits.
module md_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] rem_nx,
    output logic [W-1:0] quo_nx
);
    logic [W:0] shifted;
    logic       fits;

    always_comb begin
        shifted = {rem, quo[W-1]};
        fits    = shifted >= {1'b0, dvsr};
        rem_nx  = fits ? (shifted[W-1:0] - dvsr) : shifted[W-1:0];
        quo_nx  = {quo[W-2:0], fits};
    end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         word_sel,
    input  logic         op_div,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] acc_lo_in,
    input  logic [W-1:0] acc_hi_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] acc_lo_out,
    output logic [W-1:0] acc_hi_out,
    output logic         flag_c,
    output logic         flag_o,
    output logic         div_err
);
    localparam int B  = W / 2;
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic           wide;
        md_op_e         op;
        logic [CW-1:0]  cnt;
        logic [PW-1:0]  prod;
        logic [W-1:0]   mcand;
        logic [W-1:0]   mplier;
        logic [W-1:0]   rem;
        logic [W-1:0]   quo;
        logic [W-1:0]   dvsr;
        logic           pre_err;
        logic [W-1:0]   lo_save;
        logic [W-1:0]   hi_save;
        logic [W-1:0]   lo;
        logic [W-1:0]   hi;
        logic           cf;
        logic           of;
        logic           derr;
    } md_state_t;

    md_state_t s_q, s_d;

    logic [PW-1:0] prod_nx;
    logic [W-1:0]  mplier_nx;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  quo_nx;

    md_mul_step #(.W(W)) u_mul (
        .prod      (s_q.prod),
        .mcand     (s_q.mcand),
        .mplier    (s_q.mplier),
        .prod_nx   (prod_nx),
        .mplier_nx (mplier_nx)
    );

    md_div_step #(.W(W)) u_div (
        .rem    (s_q.rem),
        .quo    (s_q.quo),
        .dvsr   (s_q.dvsr),
        .rem_nx (rem_nx),
        .quo_nx (quo_nx)
    );

    logic [W-1:0] ld_dvsr;
    logic [W-1:0] ld_rem;
    logic         hi_nz;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        ld_dvsr  = word_sel ? operand : {{(W-B){1'b0}}, operand[B-1:0]};
        ld_rem   = word_sel ? acc_hi_in : {{(W-B){1'b0}}, acc_lo_in[W-1:B]};
        hi_nz    = 1'b0;

        if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.wide    = word_sel;
                s_d.op      = op_div ? OP_DIV : OP_MUL;
                s_d.cnt     = word_sel ? CW'(W) : CW'(B);
                s_d.prod    = '0;
                s_d.mcand   = word_sel ? acc_lo_in : {{(W-B){1'b0}}, acc_lo_in[B-1:0]};
                s_d.mplier  = word_sel ? operand : {operand[B-1:0], {(W-B){1'b0}}};
                s_d.dvsr    = ld_dvsr;
                s_d.rem     = ld_rem;
                s_d.quo     = word_sel ? acc_lo_in : {acc_lo_in[B-1:0], {(W-B){1'b0}}};
                // quotient fits only when the upper dividend half is below the divisor
                s_d.pre_err = (ld_dvsr == '0) || (ld_rem >= ld_dvsr);
                s_d.lo_save = acc_lo_in;
                s_d.hi_save = acc_hi_in;
            end
        end else begin
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.op == OP_DIV) begin
                s_d.rem = rem_nx;
                s_d.quo = quo_nx;
            end else begin
                s_d.prod   = prod_nx;
                s_d.mplier = mplier_nx;
            end

            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (s_q.op == OP_MUL) begin
                    s_d.derr = 1'b0;
                    if (s_q.wide) begin
                        s_d.hi = prod_nx[PW-1:W];
                        s_d.lo = prod_nx[W-1:0];
                        hi_nz  = |prod_nx[PW-1:W];
                    end else begin
                        s_d.hi = s_q.hi_save;
                        s_d.lo = prod_nx[W-1:0];
                        hi_nz  = |prod_nx[W-1:B];
                    end
                    s_d.cf = hi_nz;
                    s_d.of = hi_nz;
                end else if (s_q.pre_err) begin
                    s_d.derr = 1'b1;
                    s_d.lo   = s_q.lo_save;
                    s_d.hi   = s_q.hi_save;
                end else begin
                    s_d.derr = 1'b0;
                    if (s_q.wide) begin
                        s_d.lo = quo_nx;
                        s_d.hi = rem_nx;
                    end else begin
                        s_d.lo = {rem_nx[B-1:0], quo_nx[B-1:0]};
                        s_d.hi = s_q.hi_save;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign acc_lo_out = s_q.lo;
    assign acc_hi_out = s_q.hi;
    assign flag_c     = s_q.cf;
    assign flag_o     = s_q.of;
    assign div_err    = s_q.derr;
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         word_sel,
    input logic         op_div,
    input logic [W-1:0] operand,
    input logic [W-1:0] acc_lo_in,
    input logic [W-1:0] acc_hi_in,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] acc_lo_out,
    input logic [W-1:0] acc_hi_out,
    input logic         flag_c,
    input logic         flag_o,
    input logic         div_err
);
    localparam int B  = W / 2;
    localparam int CW = $clog2(W + 2);

    logic          cap_wide, cap_div;
    logic [W-1:0]  cap_lo, cap_hi;
    logic [CW-1:0] cyc;
    logic          accept;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_wide <= 1'b0;
            cap_div  <= 1'b0;
            cap_lo   <= '0;
            cap_hi   <= '0;
            cyc      <= '0;
        end else if (accept) begin
            cap_wide <= word_sel;
            cap_div  <= op_div;
            cap_lo   <= acc_lo_in;
            cap_hi   <= acc_hi_in;
            cyc      <= '0;
        end else if (busy) begin
            cyc      <= cyc + CW'(1);
        end
    end

    // R8: completion pulse lasts one cycle and never overlaps busy
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == (cap_wide ? CW'(W) : CW'(B))));
    // R9: busy rises only on a start seen while idle
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R3: multiply flags agree and clear the divide error
    assert_mul_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_div) |-> (flag_c == flag_o) && !div_err);
    // R6: divide keeps the flags
    assert_div_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_div) |-> (flag_c == $past(flag_c)) && (flag_o == $past(flag_o)));
    // R7: failed divide hands back the captured pair
    assert_div_err_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> cap_div && (acc_lo_out == cap_lo) && (acc_hi_out == cap_hi));
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(W)) u_chk (.*);

// File: tb/sim_muldiv_seq.sv
module sim_muldiv_seq;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 16;
    localparam int  WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         word_sel = 1'b0;
    logic         op_div = 1'b0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc_lo_in = '0;
    logic [W-1:0] acc_hi_in = '0;
    logic         busy, done, flag_c, flag_o, div_err;
    logic [W-1:0] acc_lo_out, acc_hi_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;
    logic exp_cf = 1'b0;
    logic exp_of = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_seq #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word_sel(word_sel), .op_div(op_div),
        .operand(operand), .acc_lo_in(acc_lo_in), .acc_hi_in(acc_hi_in),
        .busy(busy), .done(done), .acc_lo_out(acc_lo_out), .acc_hi_out(acc_hi_out),
        .flag_c(flag_c), .flag_o(flag_o), .div_err(div_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic wd, input logic dv, input logic [15:0] opnd,
                          input logic [15:0] lo, input logic [15:0] hi, input bit poke);
        logic [31:0] p, dvd, q, r;
        logic [15:0] e_lo, e_hi;
        logic        e_err;
        int          k;
        int          n;
        string       tl, th;
        n = wd ? 16 : 8;
        e_err = 1'b0;
        if (!dv) begin
            tl = wd ? "R2" : "R1";
            th = wd ? "R2" : "R1";
            if (wd) begin
                p = 32'(lo) * 32'(opnd);
                e_lo = p[15:0]; e_hi = p[31:16];
                exp_cf = (p[31:16] != 0);
            end else begin
                p = 32'(lo[7:0]) * 32'(opnd[7:0]);
                e_lo = p[15:0]; e_hi = hi;
                exp_cf = (p[15:8] != 0);
            end
            exp_of = exp_cf;
        end else begin
            tl = wd ? "R5" : "R4";
            th = wd ? "R5" : "R4";
            dvd = wd ? {hi, lo} : {16'h0, lo};
            if (wd) begin
                if (opnd == 0 || (dvd / 32'(opnd)) > 32'hFFFF) e_err = 1'b1;
                else begin q = dvd / 32'(opnd); r = dvd % 32'(opnd); e_lo = q[15:0]; e_hi = r[15:0]; end
            end else begin
                if (opnd[7:0] == 0 || (dvd / 32'(opnd[7:0])) > 32'hFF) e_err = 1'b1;
                else begin q = dvd / 32'(opnd[7:0]); r = dvd % 32'(opnd[7:0]); e_lo = {r[7:0], q[7:0]}; e_hi = hi; end
            end
            if (e_err) begin e_lo = lo; e_hi = hi; tl = "R7"; th = "R7"; end
        end

        @(negedge clk);
        word_sel = wd; op_div = dv; operand = opnd; acc_lo_in = lo; acc_hi_in = hi; start = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) start = 1'b0;
            if (poke && k == 2) begin
                // R9: second request during busy with different data
                start = 1'b1; word_sel = ~wd; op_div = ~dv;
                operand = ~opnd; acc_lo_in = ~lo; acc_hi_in = ~hi;
            end
            if (poke && k == 3) start = 1'b0;
        end while (!done && k < 40);

        check(k == n + 1, poke ? "R9 latency" : "R8 latency", k, n + 1);
        check(busy == 1'b0, "R8 busy low at done", busy, 0);
        check(acc_lo_out == e_lo, tl, acc_lo_out, e_lo);
        check(acc_hi_out == e_hi, th, acc_hi_out, e_hi);
        check(div_err == e_err, dv ? "R7 div_err" : "R3 div_err", div_err, e_err);
        check(flag_c == exp_cf, dv ? "R6 flag_c" : "R3 flag_c", flag_c, exp_cf);
        check(flag_o == exp_of, dv ? "R6 flag_o" : "R3 flag_o", flag_o, exp_of);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        check(busy == 1'b0, poke ? "R9 no restart" : "R8 idle after", busy, 0);
    endtask

    initial begin
        while (cycles < WATCHDOG && !finished) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R10: reset state
        check({busy, done, flag_c, flag_o, div_err} == 5'b0, "R10 status", {busy, done, flag_c, flag_o, div_err}, 0);
        check(acc_lo_out == 0 && acc_hi_out == 0, "R10 pair", {acc_hi_out, acc_lo_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(1'b0, 1'b0, 16'h0004, 16'h1203, 16'hBEEF, 1'b0); // R1 small, flags 0
        run_op(1'b0, 1'b0, 16'h00FF, 16'h00FF, 16'h1111, 1'b0); // R1 max, flags 1
        run_op(1'b0, 1'b1, 16'h0007, 16'h0064, 16'h2222, 1'b0); // R4, R6 keep 1
        run_op(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0); // R2 max
        run_op(1'b1, 1'b1, 16'h1234, 16'h5678, 16'h0123, 1'b0); // R5
        run_op(1'b0, 1'b1, 16'h0000, 16'h0050, 16'h3333, 1'b0); // R7 zero divisor
        run_op(1'b0, 1'b1, 16'h0010, 16'h1000, 16'h4444, 1'b0); // R7 quotient 0x100
        run_op(1'b0, 1'b1, 16'h0010, 16'h0FFF, 16'h4444, 1'b0); // R4 quotient 0xFF
        run_op(1'b1, 1'b1, 16'h0100, 16'h0000, 16'h0100, 1'b0); // R7 word overflow
        run_op(1'b1, 1'b1, 16'h0100, 16'hFFFF, 16'h00FF, 1'b0); // R5 largest fit
        run_op(1'b1, 1'b0, 16'h0002, 16'h7FFF, 16'h9999, 1'b0); // R3 flags 0
        run_op(1'b1, 1'b1, 16'h0003, 16'h0010, 16'h0000, 1'b1); // R9 poke
        run_op(1'b0, 1'b0, 16'h0033, 16'h0022, 16'h0000, 1'b1); // R9 poke

        for (int i = 0; i < 300; i++) begin
            logic wd, dv;
            logic [15:0] o, lo, hi;
            wd = 1'($urandom);
            dv = 1'($urandom);
            o  = 16'($urandom);
            lo = 16'($urandom);
            hi = 16'($urandom);
            if (dv && ($urandom % 4 != 0)) begin
                if (wd) hi = hi % (o | 16'h1);
                else lo[15:8] = lo[15:8] % (o[7:0] | 8'h1);
            end
            run_op(wd, dv, o, lo, hi, ($urandom % 8) == 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule